// File: doc/BRIEF.md
# Dual-Clock Byte-Packing FIFO with Selectable Port Widths

This block is a dual-clock first-in first-out buffer whose write side and read side each carry either one 9-bit byte or an 18-bit pair of bytes per transfer. The two widths are chosen independently. The storage holds bytes. An 18-bit write adds two bytes to the queue and a 9-bit write adds one. An 18-bit read removes two bytes and a 9-bit read removes one. A byte-order selection fixes which half of an 18-bit word carries the earlier byte of the stream.

The widths and the byte order are captured from three static pins while master reset is held. They do not change until the next master reset. A partial reset empties the queue but keeps the captured settings. The byte pointers cross between the two clock domains as Gray code through two-flop synchronizers.

Full and empty are reported in the domain that needs each flag. A write presented while the buffer is full is dropped. A read presented while it is empty is dropped. Read data is registered on the read clock.

Top module: `bm_fifo`

## Requirements
- R1: Data written in any of the four width pairings (9→9, 9→18, 18→9, 18→18) is read back in write order, with no bytes lost or duplicated.
- R2: The two width selections and the byte-order selection are captured only while `mrst` is high. Changing those pins at any other time has no effect on packing or unpacking.
- R3: With `big_end`=1, the earlier byte of a pair sits in bits [17:9] of an 18-bit word, on both write and read. With `big_end`=0, it sits in bits [8:0].
- R4: A 9-bit write takes its byte from `wdata[8:0]` and ignores `wdata[17:9]`. A 9-bit read returns the byte in `rdata[8:0]` with `rdata[17:9]` = 0.
- R5: With a 9-bit write port and an 18-bit read port, a single unpaired byte leaves `empty` high. A word becomes readable once its second byte is written.
- R6: Capacity is 2·2^AW bytes. `full` is high when fewer free bytes remain than one write transfer needs. A write while `full` is high is discarded.
- R7: A read while `empty` is high is discarded, and `rdata` keeps its last value. An accepted read updates `rdata` on the read-clock edge that accepts it.
- R8: A partial reset (`prst`) empties the buffer and keeps the captured widths and byte order.
- R9: After any reset, `empty`=1, `full`=0 and `rdata`=0.
- R10: Writes and reads may proceed at the same time on unrelated clocks. Each cross-domain pointer changes by at most one bit per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high; captures configuration |
| prst | input | 1 | Partial reset, active high; keeps configuration |
| iw_wide | input | 1 | Write port width: 1 = 18 bits, 0 = 9 bits |
| ow_wide | input | 1 | Read port width: 1 = 18 bits, 0 = 9 bits |
| big_end | input | 1 | Byte order: 1 = earlier byte in upper half |
| we | input | 1 | Write enable, sampled on `wclk` |
| wdata | input | 18 | Write data |
| re | input | 1 | Read enable, sampled on `rclk` |
| rdata | output | 18 | Registered read data |
| full | output | 1 | No room for one write transfer (`wclk` domain) |
| empty | output | 1 | Not enough data for one read transfer (`rclk` domain) |

## Verification
The bench targets three groups of corner cases.

- **Ordering and width mismatch.** It covers all four width pairings under both byte orders. An inverted byte order would show up as swapped halves. It also leaves an odd byte stranded behind an 18-bit reader; a design that exposed that byte early would deassert `empty` with half a word.
- **Buffer limits.** It fills the buffer exactly and then pushes extra writes, which a faulty full check would either accept, overwriting unread data, or refuse too early. It reads an empty buffer, which a missing guard would turn into a pointer underrun and stale data.
- **Settings and clock crossing.** It moves the configuration pins after reset and across a partial reset, which catches any design that samples them outside master reset. It runs a concurrent stream on unrelated clocks, which exposes a broken pointer handoff as lost or repeated words.

// File: rtl/bm_fifo.sv
module bm_fifo #(
  parameter int AW = 4
) (
  input  logic        wclk,
  input  logic        rclk,
  input  logic        mrst,
  input  logic        prst,
  input  logic        iw_wide,
  input  logic        ow_wide,
  input  logic        big_end,
  input  logic        we,
  input  logic [17:0] wdata,
  input  logic        re,
  output logic [17:0] rdata,
  output logic        full,
  output logic        empty
);
  localparam int BW  = AW + 1;
  localparam int PW  = AW + 2;
  localparam int CAP = 2 ** BW;

  logic c_iw, c_ow, c_be;
  logic rst;
  logic [8:0] mem [CAP];
  logic [PW-1:0] wbin, rbin, wg, rg, wg_s1, wg_s2, rg_s1, rg_s2;
  logic [PW-1:0] wstep, rstep, wnext, rnext, wbin_s, rbin_s, wused, rused;
  logic [BW-1:0] wa, ra;
  logic [8:0] b0, b1;
  logic [17:0] rword;
  logic wr_ok, rd_ok;

  function automatic logic [PW-1:0] enc(input logic [PW-1:0] b, input logic w);
    logic [PW-2:0] h;
    h = b[PW-1:1];
    return w ? {h ^ (h >> 1), 1'b0} : b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] dec(input logic [PW-1:0] g, input logic w);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return w ? {b[PW-1:1], 1'b0} : b;
  endfunction

  assign rst = mrst | prst;

  always_ff @(posedge wclk)
    if (mrst) {c_iw, c_ow, c_be} <= {iw_wide, ow_wide, big_end};

  assign wstep  = c_iw ? PW'(2) : PW'(1);
  assign rstep  = c_ow ? PW'(2) : PW'(1);
  assign rbin_s = dec(rg_s2, c_ow);
  assign wbin_s = dec(wg_s2, c_iw);
  assign wused  = wbin - rbin_s;
  assign rused  = wbin_s - rbin;
  assign full   = wused > (PW'(CAP) - wstep);
  assign empty  = rused < rstep;
  assign wr_ok  = we & ~full;
  assign rd_ok  = re & ~empty;
  assign wnext  = wbin + (wr_ok ? wstep : '0);
  assign rnext  = rbin + (rd_ok ? rstep : '0);

  always_ff @(posedge wclk)
    if (rst) begin
      wbin  <= '0;
      wg    <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      wbin  <= wnext;
      wg    <= enc(wnext, c_iw);
      rg_s1 <= rg;
      rg_s2 <= rg_s1;
    end

  assign wa = wbin[BW-1:0];

  always_ff @(posedge wclk)
    if (!rst && wr_ok) begin
      if (c_iw) begin
        mem[wa]                  <= c_be ? wdata[17:9] : wdata[8:0];
        mem[{wa[BW-1:1], 1'b1}]  <= c_be ? wdata[8:0]  : wdata[17:9];
      end else begin
        mem[wa] <= wdata[8:0];
      end
    end

  assign ra    = rbin[BW-1:0];
  assign b0    = mem[ra];
  assign b1    = mem[{ra[BW-1:1], 1'b1}];
  assign rword = c_ow ? (c_be ? {b0, b1} : {b1, b0}) : {9'd0, b0};

  always_ff @(posedge rclk)
    if (rst) begin
      rbin  <= '0;
      rg    <= '0;
      rdata <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      rbin  <= rnext;
      rg    <= enc(rnext, c_ow);
      wg_s1 <= wg;
      wg_s2 <= wg_s1;
      if (rd_ok) rdata <= rword;
    end
endmodule

module bm_fifo_chk #(
  parameter int AW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst,
  input logic          prst,
  input logic          we,
  input logic          re,
  input logic          full,
  input logic          empty,
  input logic [17:0]   rdata,
  input logic [AW+1:0] wbin,
  input logic [AW+1:0] rbin,
  input logic [AW+1:0] wg,
  input logic [AW+1:0] rg,
  input logic [AW+1:0] wused
);
  localparam int CAP = 2 ** (AW + 1);

  // R6
  full_drop_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
    (we && full) |=> $stable(wbin));

  // R6
  occupancy_cap_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
    wused <= (AW+2)'(CAP));

  // R7
  empty_drop_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
    (re && empty) |=> ($stable(rbin) && $stable(rdata)));

  // R9
  reset_empty_chk: assert property (@(posedge rclk)
    (mrst || prst) |=> (empty && rdata == 18'd0));

  // R9
  reset_notfull_chk: assert property (@(posedge wclk)
    (mrst || prst) |=> !full);

  // R10
  wgray_step_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
    $countones(wg ^ $past(wg)) <= 1);

  // R10
  rgray_step_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
    $countones(rg ^ $past(rg)) <= 1);
endmodule

bind bm_fifo bm_fifo_chk #(.AW(AW)) chk_i (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .we(we), .re(re),
  .full(full), .empty(empty), .rdata(rdata), .wbin(wbin), .rbin(rbin),
  .wg(wg), .rg(rg), .wused(wused)
);

// File: tb/bm_fifo_tb.sv
`timescale 1ns/1ps
module bm_fifo_tb_top;
  localparam int AW = 4;
  localparam int CAP = 2 ** (AW + 1);

  logic wclk = 0, rclk = 0;
  logic mrst = 1, prst = 0;
  logic iw_wide = 0, ow_wide = 0, big_end = 0;
  logic we = 0, re = 0;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;
  logic full, empty;
  bit iw, ow, be;
  int nchk = 0, nbad = 0;

  always #2 wclk = ~wclk;
  always #3 rclk = ~rclk;

  bm_fifo #(.AW(AW)) dut_i (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
    .iw_wide(iw_wide), .ow_wide(ow_wide), .big_end(big_end),
    .we(we), .wdata(wdata), .re(re), .rdata(rdata), .full(full), .empty(empty)
  );

  localparam logic [11:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b1, 9'd20}, {1'b1, 1'b1, 1'b0, 9'd32},
    {1'b0, 1'b0, 1'b0, 9'd7},  {1'b0, 1'b1, 1'b1, 9'd9},
    {1'b0, 1'b1, 1'b0, 9'd14}, {1'b1, 1'b0, 1'b1, 9'd12},
    {1'b1, 1'b0, 1'b0, 9'd32}, {1'b0, 1'b0, 1'b1, 9'd32}
  };

  function automatic logic [8:0] pat(input int s, input int k);
    return 9'((k * 73 + s * 29 + 5) % 512);
  endfunction

  function automatic logic [17:0] pair(input int s, input int k, input bit b);
    return b ? {pat(s, k), pat(s, k + 1)} : {pat(s, k + 1), pat(s, k)};
  endfunction

  task automatic chk(input string r, input logic [17:0] act, input logic [17:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic do_reset(input bit master, input bit i, input bit o, input bit b);
    iw_wide = i; ow_wide = o; big_end = b;
    if (master) mrst = 1; else prst = 1;
    repeat (4) @(negedge rclk);
    mrst = 0; prst = 0;
    if (master) begin iw = i; ow = o; be = b; end
    @(negedge rclk);
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic wr_stream(input int s, input int k0, input int n);
    for (int k = k0; k < k0 + n; k += (iw ? 2 : 1)) begin
      @(negedge wclk);
      we = 1;
      wdata = iw ? pair(s, k, be) : {9'h155, pat(s, k)};
    end
    @(negedge wclk);
    we = 0;
  endtask

  task automatic rd_check(input string r, input int s, input int k0, input int units);
    for (int u = 0; u < units; u++) begin
      @(negedge rclk); re = 1;
      @(negedge rclk); re = 0;
      chk(r, rdata, ow ? pair(s, k0 + 2 * u, be) : {9'd0, pat(s, k0 + u)});
    end
  endtask

  initial begin
    #700000;
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic [11:0] e;
    int nb;
    logic [17:0] hold;

    // R9 reset state
    do_reset(1, 0, 0, 0);
    chk("R9 empty", 18'(empty), 18'd1);
    chk("R9 full", 18'(full), 18'd0);
    chk("R9 rdata", rdata, 18'd0);

    // R1 R3 R4 vector table
    for (int v = 0; v < 8; v++) begin
      e = VEC[v];
      nb = int'(e[8:0]);
      do_reset(1, e[11], e[10], e[9]);
      wr_stream(v, 0, nb);
      settle();
      rd_check("R1/R3/R4 stream", v, 0, ow ? nb / 2 : nb);
      settle();
      chk("R1/R5 drained", 18'(empty), 18'd1);
    end

    // R5 unpaired byte
    do_reset(1, 0, 1, 1);
    wr_stream(40, 0, 1);
    settle();
    chk("R5 lone byte empty", 18'(empty), 18'd1);
    wr_stream(40, 1, 1);
    settle();
    chk("R5 pair ready", 18'(empty), 18'd0);
    rd_check("R5 pair data", 40, 0, 1);

    // R6 fill, then overflow writes dropped
    do_reset(1, 1, 1, 0);
    wr_stream(41, 0, CAP);
    chk("R6 full at capacity", 18'(full), 18'd1);
    wr_stream(77, 0, 6);
    settle();
    rd_check("R6 no overwrite", 41, 0, CAP / 2);
    settle();
    chk("R6 drained", 18'(empty), 18'd1);

    // R7 empty read ignored
    do_reset(1, 1, 1, 1);
    wr_stream(42, 0, 2);
    settle();
    rd_check("R7 first word", 42, 0, 1);
    hold = rdata;
    @(negedge rclk); re = 1;
    repeat (3) @(negedge rclk);
    re = 0;
    chk("R7 rdata held", rdata, hold);
    chk("R7 still empty", 18'(empty), 18'd1);
    wr_stream(42, 2, 2);
    settle();
    rd_check("R7 next word", 42, 2, 1);

    // R2 pins moved after reset
    do_reset(1, 1, 0, 1);
    iw_wide = 0; ow_wide = 1; big_end = 0;
    wr_stream(43, 0, 4);
    settle();
    rd_check("R2 config kept", 43, 0, 4);

    // R8 partial reset keeps settings
    do_reset(1, 0, 1, 0);
    wr_stream(44, 0, 4);
    settle();
    do_reset(0, 1, 0, 1);
    settle();
    chk("R8 emptied", 18'(empty), 18'd1);
    wr_stream(45, 0, 2);
    settle();
    rd_check("R8 settings kept", 45, 0, 1);

    // R10 concurrent traffic on unrelated clocks
    do_reset(1, 1, 1, 1);
    fork
      begin
        int i;
        i = 0;
        while (i < 100) begin
          @(negedge wclk);
          if (!full) begin we = 1; wdata = pair(46, i, 1); i += 2; end
          else we = 0;
        end
        @(negedge wclk); we = 0;
      end
      begin
        int got;
        bit pend;
        got = 0; pend = 0;
        while (got < 50) begin
          @(negedge rclk);
          if (pend) begin
            chk("R10 concurrent", rdata, pair(46, 2 * got, 1));
            got++;
          end
          re = !empty && (got + (re ? 1 : 0) < 50);
          pend = re;
        end
        re = 0;
      end
    join

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule